// File: doc/BRIEF.md
# Byte-Fetch Execute Sequencer

This block is the control and datapath of a very small accumulator machine. Its memory is word-addressed, but every instruction is one byte. On each instruction it reads the word that holds the byte at the program counter and picks the byte lane from the counter's low bits. It then advances the counter by one byte in a cycle of its own. Only after that does it execute.

Execution folds the instruction's four-bit immediate into an operand register. It routes two of the registers through a left mux and a right mux into an add/subtract unit. The unit's sum or difference is the memory address, the register result or a new program counter. Memory write data always comes from accumulator A. Prefix codes build operands wider than four bits.

Two instructions exchange a word with a channel. The channel fabric itself lies outside the block. While the fabric holds its ready input low, the block stays in execute and changes no register.

Top module: `byte_seq_core`

## Requirements
- R1: Every instruction passes through fetch, then increment, then execute, one clock each, so it takes three cycles when not stalled. With reset released before the first edge, a direct store that needs one prefix asserts `mem_we` in the sixth cycle (after the fifth rising edge).
- R2: During fetch, `mem_addr` is pc[AW+1:2]. The instruction byte is lane pc[1:0] of `mem_rdata`, where lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R3: Bits 7:4 of an instruction byte are its code and bits 3:0 its immediate. In execute the operand is the operand register OR-ed with the immediate. Every code other than 0xE and 0xF clears the operand register when it completes. Code 0xD has no other effect.
- R4: Code 0xE sets the operand register to operand<<4. Code 0xF sets it to operand<<4 with every bit from bit 8 upward set to one. This builds positive or negative operands four bits at a time.
- R5: Memory codes work as follows:
  - 0x0: A := mem[operand].
  - 0x1: B := mem[operand].
  - 0x2: mem[operand] := A.
  - 0x6: A := mem[A+operand].
  - 0x7: B := mem[B+operand].
  - 0x8: mem[B+operand] := A.
- R6: Code 0x3 sets A to the operand and code 0x4 sets B to the operand. Code 0x5 sets A to pc+operand, where pc already points at the next byte.
- R7: Code 0xC with operand 1 sets A to A+B. With operand 2 it sets A to A−B, modulo 2^W.
- R8: Branches replace the incremented pc:
  - 0x9 always sets pc := pc+operand.
  - 0xA does the same only when A is zero.
  - 0xB does the same only when A[W-1] is one.
  - 0xC with operand 0 sets pc := B.
- R9: Code 0xC with operand 5 sends and with operand 4 receives. In execute, `chan_req` is high, `chan_out` marks a send, `chan_slot` is B[1:0] and `chan_wdata` is A. The block stays in execute, with no register change, until `chan_rdy` is high at a rising edge. A receive then loads `chan_rdata` into A, and fetching resumes at the next byte.
- R10: Reset clears pc, A, B and the operand register and enters fetch. While reset is held, `mem_we` and `chan_req` are low and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | AW | Word address for fetch or data access |
| mem_rdata | input | W | Read data of the addressed word (combinational) |
| mem_wdata | output | W | Write data (accumulator A) |
| mem_we | output | 1 | Memory write enable |
| chan_req | output | 1 | Channel operation pending in execute |
| chan_out | output | 1 | 1 = send, 0 = receive |
| chan_slot | output | 2 | Link slot (B[1:0]) |
| chan_wdata | output | W | Word being sent |
| chan_rdata | input | W | Word being received |
| chan_rdy | input | 1 | Partner ready; completes the transfer at the edge |

## Verification
The end of a channel stall and the end-of-execute register updates fall on the same clock edge. At that edge the operand register is cleared, a receive writes A and the sequencer returns to fetch. The bench provokes this by holding `chan_rdy` low for several cycles during a send and during a receive, and then raising it for exactly one cycle. It judges the outcome in three ways:
- `chan_req` must stay high with stable slot and data while the transfer is stalled.
- `chan_req` must drop in the cycle after the release.
- The received word must later appear in memory through a direct store. That store only reaches the right address if the operand register was cleared and pc did not advance during the stall.

// File: rtl/byte_seq_core.sv
module byte_seq_core #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  output logic          chan_req,
  output logic          chan_out,
  output logic [1:0]    chan_slot,
  output logic [W-1:0]  chan_wdata,
  input  logic [W-1:0]  chan_rdata,
  input  logic          chan_rdy
);
  localparam int LSB = $clog2(W/8);

  typedef enum logic [1:0] {PH_FETCH, PH_INC, PH_EXEC} phase_t;
  typedef enum logic [1:0] {L_RA, L_PC, L_OP, L_ZERO} lsel_t;
  typedef enum logic [1:0] {R_RB, R_OP, R_ZERO} rsel_t;

  phase_t      phase;
  logic [W-1:0] pc, ra, rb, ro;
  logic [7:0]  ir;

  logic [W-1:0] opnd, lhs, rhs, alu, result;
  lsel_t lsel;
  rsel_t rsel;
  logic  do_sub, res_mem, wr_a, wr_b, wr_pc, st, is_ch, ch_send, pre_pos, pre_neg;
  logic  exec_go;

  assign opnd = ro | {{(W-4){1'b0}}, ir[3:0]};

  always_comb begin
    lsel = L_ZERO; rsel = R_OP; do_sub = 1'b0; res_mem = 1'b0;
    wr_a = 1'b0; wr_b = 1'b0; wr_pc = 1'b0; st = 1'b0;
    is_ch = 1'b0; ch_send = 1'b0; pre_pos = 1'b0; pre_neg = 1'b0;
    case (ir[7:4])
      4'h0: begin res_mem = 1'b1; wr_a = 1'b1; end
      4'h1: begin res_mem = 1'b1; wr_b = 1'b1; end
      4'h2: st = 1'b1;
      4'h3: wr_a = 1'b1;
      4'h4: wr_b = 1'b1;
      4'h5: begin lsel = L_PC; wr_a = 1'b1; end
      4'h6: begin lsel = L_RA; res_mem = 1'b1; wr_a = 1'b1; end
      4'h7: begin lsel = L_OP; rsel = R_RB; res_mem = 1'b1; wr_b = 1'b1; end
      4'h8: begin lsel = L_OP; rsel = R_RB; st = 1'b1; end
      4'h9: begin lsel = L_PC; wr_pc = 1'b1; end
      4'hA: begin lsel = L_PC; wr_pc = (ra == '0); end
      4'hB: begin lsel = L_PC; wr_pc = ra[W-1]; end
      4'hC: begin
        case (opnd)
          W'(0): begin lsel = L_ZERO; rsel = R_RB; wr_pc = 1'b1; end
          W'(1): begin lsel = L_RA; rsel = R_RB; wr_a = 1'b1; end
          W'(2): begin lsel = L_RA; rsel = R_RB; do_sub = 1'b1; wr_a = 1'b1; end
          W'(4): begin is_ch = 1'b1; wr_a = 1'b1; end
          W'(5): begin is_ch = 1'b1; ch_send = 1'b1; end
          default: ;
        endcase
      end
      4'hE: pre_pos = 1'b1;
      4'hF: pre_neg = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (lsel)
      L_RA:    lhs = ra;
      L_PC:    lhs = pc;
      L_OP:    lhs = opnd;
      default: lhs = '0;
    endcase
    case (rsel)
      R_RB:    rhs = rb;
      R_OP:    rhs = opnd;
      default: rhs = '0;
    endcase
  end

  assign alu     = do_sub ? lhs - rhs : lhs + rhs;
  assign result  = is_ch ? chan_rdata : (res_mem ? mem_rdata : alu);
  assign exec_go = !is_ch || chan_rdy;

  assign mem_addr   = (phase == PH_FETCH) ? pc[AW+LSB-1:LSB] : alu[AW-1:0];
  assign mem_wdata  = ra;
  assign mem_we     = (phase == PH_EXEC) && st;
  assign chan_req   = (phase == PH_EXEC) && is_ch;
  assign chan_out   = ch_send;
  assign chan_slot  = rb[1:0];
  assign chan_wdata = ra;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      pc <= '0; ra <= '0; rb <= '0; ro <= '0; ir <= '0;
    end else begin
      case (phase)
        PH_FETCH: begin
          ir    <= mem_rdata[{pc[LSB-1:0], 3'b000} +: 8];
          phase <= PH_INC;
        end
        PH_INC: begin
          pc    <= pc + W'(1);
          phase <= PH_EXEC;
        end
        default: begin
          if (exec_go) begin
            phase <= PH_FETCH;
            if (wr_a)  ra <= result;
            if (wr_b)  rb <= result;
            if (wr_pc) pc <= alu;
            if (pre_pos)      ro <= opnd << 4;
            else if (pre_neg) ro <= ({W{1'b1}} << 8) | (opnd << 4);
            else              ro <= '0;
          end
        end
      endcase
    end
  end

  p_fetch_then_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FETCH |=> phase == PH_INC);
  p_inc_then_exec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_INC |=> phase == PH_EXEC);
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_INC |=> pc == $past(pc) + W'(1));
  p_operand_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && exec_go && !pre_pos && !pre_neg) |=> ro == '0);
  p_branch_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && exec_go && wr_pc) |=> pc == $past(alu));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req && !chan_rdy) |=> (phase == PH_EXEC && $stable(pc) && $stable(ra) && $stable(ro)));
  p_no_store_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req |-> !mem_we);
endmodule

// File: tb/byte_seq_core_tb.sv
`timescale 1ns/1ps
module byte_seq_core_tb_top;
  localparam int W = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] RES = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_rdata, mem_wdata, chan_wdata, chan_rdata;
  logic mem_we, chan_req, chan_out, chan_rdy;
  logic [1:0] chan_slot;
  logic [W-1:0] mem [2**AW];

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  byte_seq_core #(.W(W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .chan_req(chan_req),
    .chan_out(chan_out), .chan_slot(chan_slot), .chan_wdata(chan_wdata),
    .chan_rdata(chan_rdata), .chan_rdy(chan_rdy));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [0:11][7:0] prog;
    logic [31:0]      exp;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{{8'hE2,8'h3A,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h0000002A}, // R6 R3
    '{{8'hE2,8'h00,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h11223344}, // R5 R2
    '{{8'h37,8'h49,8'hC1,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000010}, // R7 add
    '{{8'h37,8'h49,8'hC2,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'hFFFFFFFE}, // R7 sub
    '{{8'hF0,8'h3C,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'hFFFFFF0C}, // R4 neg
    '{{8'hE1,8'hE2,8'h33,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000123}, // R4 chain
    '{{8'hE2,8'h30,8'h61,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000005}, // R5 ind A
    '{{8'hE2,8'h40,8'h72,8'h39,8'h8C,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000009}, // R5 ind B/st
    '{{8'h31,8'h91,8'h32,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000001}, // R8 jump
    '{{8'h30,8'hA1,8'h33,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000000}, // R8 jz taken
    '{{8'h31,8'hA1,8'h33,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000003}, // R8 jz not
    '{{8'hF0,8'h30,8'hB1,8'h33,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0}, 32'hFFFFFF00}, // R8 jneg
    '{{8'h50,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0}, 32'h00000001}, // R6 pc rel
    '{{8'h45,8'hC0,8'h33,8'hD0,8'hD0,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0}, 32'h00000000}  // R8 via B
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [0:11][7:0] p);
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    for (int k = 0; k < 3; k++) mem[k] = {p[4*k+3], p[4*k+2], p[4*k+1], p[4*k]};
    mem[8'h20] = 32'h11223344;
    mem[8'h21] = 32'h00000005;
    mem[8'h22] = 32'h00000024;
    mem[RES]   = 32'hDEADBEEF;
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    chan_rdy = 1'b0;
    chan_rdata = '0;
    load(VECS[0].prog);

    // R10 reset state
    cycles(2);
    check("R10 mem_we", {31'b0, mem_we}, 32'h0);
    check("R10 chan_req", {31'b0, chan_req}, 32'h0);
    check("R10 mem_addr", {24'b0, mem_addr}, 32'h0);

    // R1/R2 timing of a prefixed direct store
    load({8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0,8'hD0});
    rst_n = 1'b1;
    check("R2 first fetch addr", {24'b0, mem_addr}, 32'h0);
    for (int k = 1; k <= 5; k++) begin
      if (k < 5) begin
        @(negedge clk);
        check("R1 no early store", {31'b0, mem_we}, 32'h0);
      end else begin
        @(negedge clk);
        check("R1 store in sixth cycle", {31'b0, mem_we}, 32'h1);
        check("R3 store address", {24'b0, mem_addr}, {24'b0, RES});
      end
    end

    // vector table
    for (int v = 0; v < 14; v++) begin
      restart();
      load(VECS[v].prog);
      rst_n = 1'b1;
      cycles(80);
      check($sformatf("vector %0d result", v), mem[RES], VECS[v].exp);
    end

    // R9 channel stall: send 7 on slot 2, then receive
    restart();
    load({8'h37,8'h42,8'hC5,8'hC4,8'hE3,8'h20,8'hFF,8'h9E,8'hD0,8'hD0,8'hD0,8'hD0});
    rst_n = 1'b1;
    for (int i = 0; i < 40 && !chan_req; i++) @(negedge clk);
    check("R9 send req", {31'b0, chan_req}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      check("R9 send held", {29'b0, chan_req, chan_out, 1'b0}, 32'h6);
      check("R9 send slot/data", {chan_slot, chan_wdata[29:0]}, {2'd2, 30'd7});
      @(negedge clk);
    end
    chan_rdy = 1'b1;
    @(negedge clk);
    chan_rdy = 1'b0;
    check("R9 released", {31'b0, chan_req}, 32'h0);
    for (int i = 0; i < 10 && !chan_req; i++) @(negedge clk);
    check("R9 recv req", {30'b0, chan_req, chan_out}, 32'h2);
    cycles(3);
    check("R9 recv still held", {31'b0, chan_req}, 32'h1);
    chan_rdata = 32'hCAFE0001;
    chan_rdy = 1'b1;
    @(negedge clk);
    chan_rdy = 1'b0;
    chan_rdata = '0;
    cycles(20);
    check("R9 received word stored", mem[RES], 32'hCAFE0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule